// File: doc/BRIEF.md
# Coupler Host Register Interface (I2C Slave)

This block is the two-wire serial slave that sits between a host controller and the register set of a contactless coupler. It watches the synchronised clock and data lines, finds START and STOP conditions, matches a 7-bit device select byte and acknowledges it. It then gives the host byte access to three things: a one-byte configuration register, a 36-byte frame buffer that is streamed one byte per transfer, and a write-only trigger that starts an anticollision run.

The frame buffer itself lives in the modem side of the coupler. This block drives its index, write data and write enable, and takes its read data back. When a transaction writes to the frame buffer or to the trigger, the block raises a one-cycle strobe after the closing STOP, which tells the modem to start work. While the modem reports an RF exchange in progress, the block withholds the acknowledge for its select byte. The host can therefore poll until the coupler answers.

Top module: `cpl_i2c_regif`

## Requirements
- R1: The select byte is {DEV_HI[3:0], chip_sel_i[2], chip_sel_i[1], chip_sel_i[0], rw}, sent MSB first, with rw=1 for a read. On a match the slave pulls SDA low in the following acknowledge slot. On a mismatch it does not acknowledge, and the rest of the transaction has no effect.
- R2: While rf_busy_i is high during the select byte, the slave does not acknowledge it.
- R3: Bits travel MSB first. A write transaction is select byte, register address byte, then data bytes. Register 00h is the configuration register: it resets to 00h, a written byte appears on param_o, and it reads back unchanged.
- R4: Data bytes written to register 01h go out on the buffer port (buf_we_o high for one cycle) at indices 0, 1, 2 and so on. The index restarts at 0 on every START and on every register address byte. Bytes beyond index 35 are not acknowledged and cause no buffer write.
- R5: Reading register 01h returns buf_rdata_i for indices 0, 1, 2 and so on, starting at 0 in each transaction. Beyond index 35 it returns FFh.
- R6: Reading register 03h, or the reserved addresses 02h, 04h and 05h, returns FFh. A write to a reserved address changes neither param_o nor any strobe.
- R7: A random-address read (address write, repeated START, read) uses the new address. A read without an address phase uses the last address that was set.
- R8: frame_load_o pulses for exactly one cycle after the STOP of a transaction that wrote at least one byte to 01h. It does not pulse otherwise.
- R9: acoll_start_o pulses for one cycle after the STOP of a transaction that wrote a byte to 03h. It does not pulse for other registers.
- R10: When the host does not acknowledge a read byte, the slave releases SDA and ignores clocks until the next START.
- R11: The slave changes sda_oe_o only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line, unsynchronised |
| sda_i | input | 1 | Serial data line as seen on the wire, unsynchronised |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| chip_sel_i | input | 3 | Pin-strapped low bits of the select code |
| rf_busy_i | input | 1 | RF exchange in progress; the select byte is refused |
| param_o | output | 8 | Configuration register contents |
| buf_addr_o | output | 6 | Frame buffer byte index |
| buf_wdata_o | output | 8 | Frame buffer write data |
| buf_we_o | output | 1 | Frame buffer write enable, one cycle |
| buf_rdata_i | input | 8 | Frame buffer read data at buf_addr_o |
| frame_load_o | output | 1 | Frame written, pulsed after STOP |
| acoll_start_o | output | 1 | Anticollision trigger, pulsed after STOP |

## Verification
Directed transactions cover the boundaries: a frame write and a frame read that run two bytes past the 36-byte end, reads of every non-readable address, a host NACK in the middle of a read, a mismatched select code and a busy refusal. These show apart pointer overrun, read-mux defaults and end-of-read release. Seeded random rounds then mix configuration writes with read-back, frame writes of random length with read-back, and writes to a wrong select code under random strap values. These separate correct strap decoding and per-transaction index restart from behaviour that only works for one fixed address or length. A bench monitor of the data enable against the clock line checks the timing of every transaction.

// File: rtl/cpl_i2c_pkg.sv
package cpl_i2c_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DACK, ST_REG, ST_RACK,
    ST_WR, ST_WACK, ST_RD, ST_MACK
  } i2c_st_e;

  localparam logic [7:0] REG_PARAM = 8'h00;
  localparam logic [7:0] REG_FRAME = 8'h01;
  localparam logic [7:0] REG_TRIG  = 8'h03;
  localparam logic [7:0] FILL_BYTE = 8'hFF;

  // Select byte: upper seven bits must equal {fixed high nibble, strap pins}
  function automatic logic dev_match(input logic [7:0] sel,
                                     input logic [3:0] hi,
                                     input logic [2:0] cs);
    return sel[7:1] == {hi, cs};
  endfunction

  // Byte returned to the host for a given register pointer
  function automatic logic [7:0] rd_value(input logic [7:0] ptr,
                                          input logic [7:0] par,
                                          input logic [7:0] bdat,
                                          input logic       in_rng);
    case (ptr)
      REG_PARAM: return par;
      REG_FRAME: return in_rng ? bdat : FILL_BYTE;
      default:   return FILL_BYTE;
    endcase
  endfunction

endpackage

// File: rtl/cpl_i2c_sync.sv
module cpl_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_p    <= scl_pipe[STAGES-1];
      sda_p    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/cpl_i2c_engine.sv
module cpl_i2c_engine
  import cpl_i2c_pkg::*;
#(
  parameter logic [3:0] DEV_HI = 4'hA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [2:0] chip_sel,
  input  logic       rf_busy,
  input  logic [7:0] rd_byte,
  input  logic       wr_ok,
  output logic       sda_oe,
  output logic [7:0] rx_byte,
  output logic       addr_ev,
  output logic       wr_ev,
  output logic       rd_ev,
  output logic       in_dack
);
  i2c_st_e    st;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic       rw_q, mack_q;

  assign rx_byte = sh;
  assign in_dack = (st == ST_DACK);
  assign addr_ev = scl_fall && st == ST_REG && cnt == 4'd8;
  assign wr_ev   = scl_fall && st == ST_WR  && cnt == 4'd8;
  assign rd_ev   = scl_fall && ((st == ST_DACK && rw_q) || (st == ST_MACK && mack_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_ev) begin
      st     <= ST_DEV;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_ev) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (scl_rise) begin
      case (st)
        ST_DEV, ST_REG, ST_WR: begin
          sh  <= {sh[6:0], sda_s};
          cnt <= cnt + 4'd1;
        end
        ST_MACK: mack_q <= ~sda_s;
        default: ;
      endcase
    end else if (scl_fall) begin
      case (st)
        ST_DEV: if (cnt == 4'd8) begin
          if (dev_match(sh, DEV_HI, chip_sel) && !rf_busy) begin
            st     <= ST_DACK;
            sda_oe <= 1'b1;
            rw_q   <= sh[0];
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_DACK: begin
          cnt <= '0;
          if (rw_q) begin
            st     <= ST_RD;
            sh     <= rd_byte;
            sda_oe <= ~rd_byte[7];
          end else begin
            st     <= ST_REG;
            sda_oe <= 1'b0;
          end
        end
        ST_REG: if (cnt == 4'd8) begin
          st     <= ST_RACK;
          sda_oe <= 1'b1;
        end
        ST_RACK, ST_WACK: begin
          st     <= ST_WR;
          cnt    <= '0;
          sda_oe <= 1'b0;
        end
        ST_WR: if (cnt == 4'd8) begin
          st     <= ST_WACK;
          sda_oe <= wr_ok;
        end
        ST_RD: begin
          if (cnt == 4'd7) begin
            st     <= ST_MACK;
            sda_oe <= 1'b0;
          end else begin
            sh     <= {sh[6:0], 1'b0};
            sda_oe <= ~sh[6];
            cnt    <= cnt + 4'd1;
          end
        end
        ST_MACK: begin
          cnt <= '0;
          if (mack_q) begin
            st     <= ST_RD;
            sh     <= rd_byte;
            sda_oe <= ~rd_byte[7];
          end else begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cpl_i2c_regmap.sv
module cpl_i2c_regmap
  import cpl_i2c_pkg::*;
#(
  parameter int BUF_BYTES = 36,
  localparam int IDXW     = $clog2(BUF_BYTES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_ev,
  input  logic            stop_ev,
  input  logic            addr_ev,
  input  logic            wr_ev,
  input  logic            rd_ev,
  input  logic [7:0]      rx_byte,
  output logic            wr_ok,
  output logic [7:0]      rd_byte,
  output logic [7:0]      param_o,
  output logic [IDXW-1:0] buf_addr_o,
  output logic [7:0]      buf_wdata_o,
  output logic            buf_we_o,
  input  logic [7:0]      buf_rdata_i,
  output logic            frame_load_o,
  output logic            acoll_start_o
);
  logic [7:0]      ptr_q;
  logic [IDXW-1:0] idx_q;
  logic            frame_pend, acoll_pend;
  logic            in_rng, is_frame;

  assign in_rng      = idx_q < IDXW'(BUF_BYTES);
  assign is_frame    = ptr_q == REG_FRAME;
  assign wr_ok       = !(is_frame && !in_rng);
  assign rd_byte     = rd_value(ptr_q, param_o, buf_rdata_i, in_rng);
  assign buf_addr_o  = idx_q;
  assign buf_wdata_o = rx_byte;
  assign buf_we_o    = wr_ev && is_frame && in_rng;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q         <= REG_PARAM;
      idx_q         <= '0;
      param_o       <= 8'h00;
      frame_pend    <= 1'b0;
      acoll_pend    <= 1'b0;
      frame_load_o  <= 1'b0;
      acoll_start_o <= 1'b0;
    end else begin
      frame_load_o  <= 1'b0;
      acoll_start_o <= 1'b0;
      if (start_ev) begin
        idx_q <= '0;
      end else if (stop_ev) begin
        frame_load_o  <= frame_pend;
        acoll_start_o <= acoll_pend;
        frame_pend    <= 1'b0;
        acoll_pend    <= 1'b0;
      end else if (addr_ev) begin
        ptr_q <= rx_byte;
        idx_q <= '0;
      end else if (wr_ev) begin
        case (ptr_q)
          REG_PARAM: param_o <= rx_byte;
          REG_FRAME: if (in_rng) begin
            idx_q      <= idx_q + 1'b1;
            frame_pend <= 1'b1;
          end
          REG_TRIG:  acoll_pend <= 1'b1;
          default: ;
        endcase
      end else if (rd_ev && is_frame && in_rng) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cpl_i2c_regif.sv
module cpl_i2c_regif #(
  parameter logic [3:0] DEV_HI      = 4'hA,
  parameter int         BUF_BYTES   = 36,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             scl_i,
  input  logic                             sda_i,
  output logic                             sda_oe_o,
  input  logic [2:0]                       chip_sel_i,
  input  logic                             rf_busy_i,
  output logic [7:0]                       param_o,
  output logic [$clog2(BUF_BYTES+1)-1:0]   buf_addr_o,
  output logic [7:0]                       buf_wdata_o,
  output logic                             buf_we_o,
  input  logic [7:0]                       buf_rdata_i,
  output logic                             frame_load_o,
  output logic                             acoll_start_o
);
  // Named internal events, also observed by the bound checker
  logic       scl_s_w, sda_s_w, scl_rise_w, scl_fall_w, start_w, stop_w;
  logic       addr_ev_w, wr_ev_w, rd_ev_w, wr_ok_w, in_dack_w;
  logic [7:0] rx_byte_w, rd_byte_w;

  cpl_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s_w), .sda_s(sda_s_w), .scl_rise(scl_rise_w),
    .scl_fall(scl_fall_w), .start_ev(start_w), .stop_ev(stop_w)
  );

  cpl_i2c_engine #(.DEV_HI(DEV_HI)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s_w), .scl_rise(scl_rise_w),
    .scl_fall(scl_fall_w), .start_ev(start_w), .stop_ev(stop_w),
    .chip_sel(chip_sel_i), .rf_busy(rf_busy_i), .rd_byte(rd_byte_w),
    .wr_ok(wr_ok_w), .sda_oe(sda_oe_o), .rx_byte(rx_byte_w),
    .addr_ev(addr_ev_w), .wr_ev(wr_ev_w), .rd_ev(rd_ev_w), .in_dack(in_dack_w)
  );

  cpl_i2c_regmap #(.BUF_BYTES(BUF_BYTES)) u_map (
    .clk(clk), .rst_n(rst_n), .start_ev(start_w), .stop_ev(stop_w),
    .addr_ev(addr_ev_w), .wr_ev(wr_ev_w), .rd_ev(rd_ev_w), .rx_byte(rx_byte_w),
    .wr_ok(wr_ok_w), .rd_byte(rd_byte_w), .param_o(param_o),
    .buf_addr_o(buf_addr_o), .buf_wdata_o(buf_wdata_o), .buf_we_o(buf_we_o),
    .buf_rdata_i(buf_rdata_i), .frame_load_o(frame_load_o),
    .acoll_start_o(acoll_start_o)
  );

endmodule

// File: rtl/cpl_i2c_regif_chk.sv
module cpl_i2c_regif_chk #(
  parameter int BUF_BYTES = 36,
  localparam int IDXW     = $clog2(BUF_BYTES + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            scl_s,
  input logic            scl_rise,
  input logic            scl_fall,
  input logic            start_ev,
  input logic            stop_ev,
  input logic            sda_oe,
  input logic            in_dack,
  input logic            rf_busy,
  input logic            buf_we,
  input logic [IDXW-1:0] buf_addr,
  input logic            frame_load,
  input logic            acoll_start
);
  AST_OE_HELD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe)); // R11
  AST_BUS_EVENTS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_ev, stop_ev, scl_rise, scl_fall})); // R3
  AST_SELECT_ACK_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    in_dack |-> sda_oe); // R1
  AST_BUSY_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_dack) |-> !$past(rf_busy)); // R2
  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (int'(buf_addr) < BUF_BYTES)); // R4
  AST_START_CLEARS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (buf_addr == '0)); // R4
  AST_FRAME_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_load |-> ($past(stop_ev) && !$past(frame_load))); // R8
  AST_ACOLL_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    acoll_start |-> $past(stop_ev)); // R9
endmodule

bind cpl_i2c_regif cpl_i2c_regif_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s_w), .scl_rise(scl_rise_w),
  .scl_fall(scl_fall_w), .start_ev(start_w), .stop_ev(stop_w),
  .sda_oe(sda_oe_o), .in_dack(in_dack_w), .rf_busy(rf_busy_i),
  .buf_we(buf_we_o), .buf_addr(buf_addr_o), .frame_load(frame_load_o),
  .acoll_start(acoll_start_o)
);

// File: tb/cpl_i2c_regif_tb.sv
module cpl_i2c_regif_tb;
  localparam int Q = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [2:0] dut_cs = 3'd5;
  logic rf_busy = 1'b0;
  logic [7:0] param;
  logic [5:0] baddr;
  logic [7:0] bwdata, brdata;
  logic bwe, fload, acoll;
  wire  sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  cpl_i2c_regif u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .chip_sel_i(dut_cs), .rf_busy_i(rf_busy), .param_o(param),
    .buf_addr_o(baddr), .buf_wdata_o(bwdata), .buf_we_o(bwe),
    .buf_rdata_i(brdata), .frame_load_o(fload), .acoll_start_o(acoll)
  );

  // Environment frame memory and port observers
  logic [7:0] bmem [0:63];
  logic [5:0] wlog_a [0:63];
  logic [7:0] wlog_d [0:63];
  int n_wr = 0, n_fl = 0, n_ac = 0;
  assign brdata = bmem[baddr];
  always @(posedge clk) begin
    if (bwe) begin
      if (n_wr < 64) begin wlog_a[n_wr] = baddr; wlog_d[n_wr] = bwdata; end
      n_wr++;
      bmem[baddr] = bwdata;
    end
    if (fload) n_fl++;
    if (acoll) n_ac++;
  end

  int total = 0, bad = 0;
  logic done = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // R11 monitor: data enable may move only while the clock line is low
  logic prev_scl = 1'b1, prev_oe = 1'b0;
  int r11_err = 0;
  always @(negedge clk) begin
    if (rst_n && scl && prev_scl && sda_oe !== prev_oe) r11_err++;
    prev_scl = scl; prev_oe = sda_oe;
  end

  function automatic logic [7:0] sel_byte(input logic [2:0] cs, input logic rw);
    return {4'hA, cs, rw};
  endfunction

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(); scl = 1'b1; qw(); sda_m = 1'b0; qw(); scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic send8(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
    end
    sda_m = 1'b1; qw(); scl = 1'b1; qw(); ack = ~sda_line; qw(); scl = 1'b0; qw();
  endtask

  task automatic recv8(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      qw(); scl = 1'b1; qw(); b = {b[6:0], sda_line}; qw(); scl = 1'b0;
    end
    qw(); sda_m = ~give_ack; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw(); sda_m = 1'b1;
  endtask

  logic [7:0] tx [0:63];
  logic [7:0] rx [0:63];

  task automatic do_write(input logic [2:0] cs, input logic [7:0] ra, input int n,
                          output logic dack, output int dacks);
    logic a;
    dacks = 0;
    bus_start();
    send8(sel_byte(cs, 1'b0), dack);
    if (dack) begin
      send8(ra, a);
      for (int i = 0; i < n; i++) begin send8(tx[i], a); if (a) dacks++; end
    end
    bus_stop();
    qw();
  endtask

  task automatic do_read(input logic [2:0] cs, input logic use_ra, input logic [7:0] ra,
                         input int n, output logic dack);
    logic a;
    bus_start();
    if (use_ra) begin
      send8(sel_byte(cs, 1'b0), a);
      send8(ra, a);
      bus_start();
    end
    send8(sel_byte(cs, 1'b1), dack);
    if (dack) for (int i = 0; i < n; i++) recv8(i != n - 1, rx[i]);
    bus_stop();
    qw();
  endtask

  function automatic logic [7:0] exp_frame_rd(input int i);
    return (i < 36) ? bmem[i] : 8'hFF;
  endfunction

  initial begin
    logic da;
    int   na, fl0, ac0, wr0;
    logic [7:0] pv;
    for (int i = 0; i < 64; i++) bmem[i] = 8'h00;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // Reset state
    chk("R3", "param after reset", param, 8'h00);
    chk("R1", "sda released after reset", sda_oe, 1'b0);
    chk("R8", "no strobe after reset", {fload, acoll}, 2'b00);

    // R3 config write, R7 random-address read back
    tx[0] = 8'h5C;
    do_write(3'd5, 8'h00, 1, da, na);
    chk("R1", "select ack", da, 1'b1);
    chk("R3", "param written", param, 8'h5C);
    do_read(3'd5, 1'b1, 8'h00, 1, da);
    chk("R7", "random read param", rx[0], 8'h5C);
    do_read(3'd5, 1'b0, 8'h00, 2, da);
    chk("R7", "current read param", rx[0], 8'h5C);

    // R1 wrong strap bits: no ack, no effect
    tx[0] = 8'h11;
    do_write(3'd4, 8'h00, 1, da, na);
    chk("R1", "mismatch nack", da, 1'b0);
    chk("R1", "mismatch no write", param, 8'h5C);

    // R2 busy refusal
    rf_busy = 1'b1;
    do_write(3'd5, 8'h00, 1, da, na);
    rf_busy = 1'b0;
    chk("R2", "busy nack", da, 1'b0);
    chk("R2", "busy no write", param, 8'h5C);

    // R4/R8 short frame write
    wr0 = n_wr; fl0 = n_fl; ac0 = n_ac;
    for (int i = 0; i < 5; i++) tx[i] = 8'(8'h30 + i);
    do_write(3'd5, 8'h01, 5, da, na);
    chk("R4", "frame writes count", n_wr - wr0, 5);
    for (int i = 0; i < 5; i++) begin
      chk("R4", "frame write index", wlog_a[wr0 + i], 6'(i));
      chk("R4", "frame write data", wlog_d[wr0 + i], tx[i]);
    end
    chk("R8", "frame strobe once", n_fl - fl0, 1);
    chk("R9", "no acoll on frame write", n_ac - ac0, 0);

    // R4 overrun: 38 bytes, last two refused
    wr0 = n_wr;
    for (int i = 0; i < 38; i++) tx[i] = 8'($urandom);
    do_write(3'd5, 8'h01, 38, da, na);
    chk("R4", "acked bytes to end", na, 36);
    chk("R4", "writes capped", n_wr - wr0, 36);

    // R5 read past end
    do_read(3'd5, 1'b1, 8'h01, 38, da);
    for (int i = 0; i < 38; i++) chk("R5", "frame read byte", rx[i], exp_frame_rd(i));

    // R7 current-address read restarts at index 0
    do_read(3'd5, 1'b0, 8'h00, 3, da);
    for (int i = 0; i < 3; i++) chk("R7", "current frame read", rx[i], bmem[i]);

    // R6 non-readable addresses
    do_read(3'd5, 1'b1, 8'h03, 1, da);
    chk("R6", "trigger reads FF", rx[0], 8'hFF);
    do_read(3'd5, 1'b1, 8'h02, 1, da);
    chk("R6", "reserved 02 reads FF", rx[0], 8'hFF);
    do_read(3'd5, 1'b1, 8'h04, 1, da);
    chk("R6", "reserved 04 reads FF", rx[0], 8'hFF);
    do_read(3'd5, 1'b1, 8'h05, 1, da);
    chk("R6", "reserved 05 reads FF", rx[0], 8'hFF);
    fl0 = n_fl; ac0 = n_ac;
    tx[0] = 8'h99;
    do_write(3'd5, 8'h04, 1, da, na);
    chk("R6", "reserved write param kept", param, 8'h5C);
    chk("R6", "reserved write no strobe", (n_fl - fl0) + (n_ac - ac0), 0);

    // R9 trigger write
    fl0 = n_fl; ac0 = n_ac;
    tx[0] = 8'h01;
    do_write(3'd5, 8'h03, 1, da, na);
    chk("R9", "acoll strobe once", n_ac - ac0, 1);
    chk("R8", "no frame strobe on trigger", n_fl - fl0, 0);

    // R10 host NACK releases the line until next START
    bus_start();
    send8(sel_byte(3'd5, 1'b0), da);
    send8(8'h00, da);
    bus_start();
    send8(sel_byte(3'd5, 1'b1), da);
    recv8(1'b0, rx[0]);
    chk("R10", "read after nack value", rx[0], 8'h5C);
    for (int i = 0; i < 9; i++) begin
      qw(); scl = 1'b1; qw(); qw(); scl = 1'b0;
      if (sda_oe !== 1'b0) chk("R10", "line released after nack", sda_oe, 1'b0);
    end
    qw();
    bus_stop(); qw();
    do_read(3'd5, 1'b1, 8'h00, 1, da);
    chk("R10", "next transaction works", rx[0], 8'h5C);

    // Seeded random rounds
    for (int r = 0; r < 10; r++) begin
      int op;
      dut_cs = 3'($urandom);
      op = int'($urandom % 3);
      if (op == 0) begin
        pv = 8'($urandom); tx[0] = pv;
        do_write(dut_cs, 8'h00, 1, da, na);
        chk("R3", "rand param write", param, pv);
        do_read(dut_cs, 1'b1, 8'h00, 1, da);
        chk("R7", "rand param read", rx[0], pv);
      end else if (op == 1) begin
        int n;
        n = 1 + int'($urandom % 8);
        wr0 = n_wr; fl0 = n_fl;
        for (int i = 0; i < n; i++) tx[i] = 8'($urandom);
        do_write(dut_cs, 8'h01, n, da, na);
        chk("R4", "rand frame writes", n_wr - wr0, n);
        chk("R8", "rand frame strobe", n_fl - fl0, 1);
        do_read(dut_cs, 1'b1, 8'h01, n, da);
        for (int i = 0; i < n; i++) chk("R5", "rand frame read", rx[i], tx[i]);
      end else begin
        pv = param;
        tx[0] = 8'($urandom);
        do_write(dut_cs ^ 3'(1 + $urandom % 7), 8'h00, 1, da, na);
        chk("R1", "rand mismatch nack", da, 1'b0);
        chk("R1", "rand mismatch no write", param, pv);
      end
    end

    chk("R11", "enable changes with clock high", r11_err, 0);
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule